// File: doc/BRIEF.md
# Shared-Level Interrupt Request Latch Bank

This block holds one pending flag per interrupt priority level. Most levels have a single request source of their own. Two levels, 15 and 16, are each shared by a pair of sources, and a one-byte select register chooses which member of each pair may reach the level's flag. A request from the member that is not chosen is discarded. It is not parked anywhere, so it cannot show up later when the select bit changes.

A flag is set by a one-cycle request pulse. It stays set until one of three things happens: the processor accepts that level (acknowledge strobe plus level index), software clears it with a per-level clear strobe, or reset. The block continuously reports the pending vector. Level 0 is the most urgent, so the block also reports the lowest-numbered pending level, together with a flag that is low when nothing is pending. The interrupt controller uses these outputs to start its acceptance sequence.

Top module: `shirq_latch_top`

## Requirements
- R1: After reset every pending flag is 0, `top_valid` is 0, and both select bits are 0. With both bits at 0, the level-15 pair routes `irq_req[15]` and the level-16 pair routes `irq_req[16]`.
- R2: A one-cycle pulse on `irq_req[i]` of an unshared level i sets `pending[i]` from the next clock edge on.
- R3: Level 15 uses select bit 1 of the byte. At 0, `irq_req[15]` sets the level and `irq_alt_req[0]` (serial-transmit done) is dropped. At 1, `irq_alt_req[0]` sets it and `irq_req[15]` is dropped.
- R4: Level 16 uses select bit 0 of the byte. At 0, `irq_req[16]` sets the level and `irq_alt_req[1]` (conversion done) is dropped. At 1, `irq_alt_req[1]` sets it and `irq_req[16]` is dropped.
- R5: Bits 7 to 2 of a select write have no effect on routing.
- R6: A set flag stays set until it is accepted. An acknowledge with `ack_level` = i clears only flag i.
- R7: A 1 on bit i of `sw_clear` clears flag i at the next edge.
- R8: When a set request and a clear or acknowledge of the same level fall in the same cycle, the flag ends up set.
- R9: `top_level` is the lowest-numbered pending level and `top_valid` is 1. When no flag is set, `top_valid` is 0.
- R10: Writing the select register does not change any flag that is already set.
- R11: A select write takes effect for requests from the following cycle on. A request in the same cycle as the write is routed by the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_LEVELS | Primary request pulse per level |
| irq_alt_req | input | 2 | Alternate sources: bit 0 serial-transmit (level 15), bit 1 conversion done (level 16) |
| sel_wr_en | input | 1 | Select register write strobe |
| sel_wr_data | input | 8 | Select register write byte |
| sw_clear | input | NUM_LEVELS | Per-level software clear strobes |
| ack_valid | input | 1 | Acceptance strobe |
| ack_level | input | LVL_W | Index of the level being accepted |
| pending | output | NUM_LEVELS | Pending flag vector |
| top_valid | output | 1 | At least one flag is set |
| top_level | output | LVL_W | Lowest-numbered pending level |

## Verification
A request can land on a level in the very cycle that software clears it or the processor accepts it, so setting and clearing meet in one cycle. The bench drives a pulse on `irq_req[15]` together with a `sw_clear` bit, and separately together with an acknowledge of level 15. It then reads `pending` after the edge and expects the flag still set. A dropped request meeting a clear in the same cycle is also driven, and there the clear must win, because the gated request never reaches the flag.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
    // number of level pairs that share a flag
    localparam int PAIR_CNT   = 2;
    localparam int SEL_BYTE_W = 8;

    // level served by each pair (pair 0 -> 15, pair 1 -> 16)
    function automatic int pair_level(input int p);
        return (p == 0) ? 15 : 16;
    endfunction

    // select-byte bit controlling each pair (pair 0 -> bit 1, pair 1 -> bit 0)
    function automatic int pair_sel_bit(input int p);
        return (p == 0) ? 1 : 0;
    endfunction

    typedef logic [PAIR_CNT-1:0] sel_vec_t;

    typedef struct packed {
        sel_vec_t sel;
    } sel_state_t;
endpackage

// File: rtl/shirq_sel_reg.sv
module shirq_sel_reg
    import shirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_BYTE_W-1:0] wr_data,
    output sel_vec_t              sel_q_o
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int p = 0; p < PAIR_CNT; p++) begin
                st_d.sel[p] = wr_data[pair_sel_bit(p)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q_o = st_q.sel;

    // R11: without a write the routing setting does not move
    assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.sel));

    // R5: only bits 1 and 0 of the byte reach the setting
    assert_sel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.sel[0] == $past(wr_data[1])) && (st_q.sel[1] == $past(wr_data[0])));
endmodule

// File: rtl/shirq_route.sv
module shirq_route
    import shirq_pkg::*;
#(
    parameter int NUM_LEVELS = 20
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  sel_vec_t              sel,
    input  logic [NUM_LEVELS-1:0] req,
    input  logic [PAIR_CNT-1:0]   alt_req,
    output logic [NUM_LEVELS-1:0] set_vec
);
    logic [NUM_LEVELS-1:0] shared_mask;

    always_comb begin
        shared_mask = '0;
        for (int p = 0; p < PAIR_CNT; p++) begin
            shared_mask[pair_level(p)] = 1'b1;
        end
    end

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
        if (lv == 15 || lv == 16) begin : g_shared
            localparam int PIDX = (lv == 15) ? 0 : 1;
            logic pick_alt;
            assign pick_alt    = sel[PIDX];
            assign set_vec[lv] = pick_alt ? alt_req[PIDX] : req[lv];

            // R3 (pair 0) and R4 (pair 1): the unchosen source never sets the flag
            assert_unsel_drop_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (pick_alt && !alt_req[PIDX]) || (!pick_alt && !req[lv]) |-> !set_vec[lv]);
        end else begin : g_plain
            assign set_vec[lv] = req[lv];
        end
    end

    // R2: unshared levels pass their request straight through
    assert_plain_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec ^ req) & ~shared_mask) == '0);
endmodule

// File: rtl/shirq_latch_bank.sv
module shirq_latch_bank #(
    parameter int NUM_LEVELS = 20,
    parameter int LVL_W      = 5
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] set_vec,
    input  logic [NUM_LEVELS-1:0] clr_vec,
    input  logic                  ack_valid,
    input  logic [LVL_W-1:0]      ack_level,
    output logic [NUM_LEVELS-1:0] pending_o
);
    typedef struct packed {
        logic [NUM_LEVELS-1:0] pend;
    } bank_state_t;

    bank_state_t           st_d, st_q;
    logic [NUM_LEVELS-1:0] ack_hot;
    logic [NUM_LEVELS-1:0] drop_vec;

    always_comb begin
        for (int i = 0; i < NUM_LEVELS; i++) begin
            ack_hot[i] = ack_valid && (ack_level == LVL_W'(i));
        end
        drop_vec = clr_vec | ack_hot;
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~drop_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pend;

    // R8 / R2: every request that reaches the bank is visible after the edge
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st_q.pend & $past(set_vec)) == $past(set_vec)));

    // R6: flags fall only where a clear or acknowledge was applied
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.pend) & ~$past(drop_vec) & ~st_q.pend) == '0));

    // R6: an acknowledge names at most one level
    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hot));
endmodule

// File: rtl/shirq_prio.sv
module shirq_prio #(
    parameter int NUM_LEVELS = 20,
    parameter int LVL_W      = 5
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] pending,
    output logic                  top_valid,
    output logic [LVL_W-1:0]      top_level
);
    always_comb begin
        top_valid = 1'b0;
        top_level = '0;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (pending[i]) begin
                top_valid = 1'b1;
                top_level = LVL_W'(i);
            end
        end
    end

    // R9: the reported level is pending
    assert_top_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> pending[top_level]);

    // R9: nothing below the reported level is pending
    assert_top_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ((pending & ((NUM_LEVELS'(1) << top_level) - NUM_LEVELS'(1))) == '0));

    // R9: idle flag when empty
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !top_valid);
endmodule

// File: rtl/shirq_latch_top.sv
module shirq_latch_top
    import shirq_pkg::*;
#(
    parameter int NUM_LEVELS = 20,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] irq_req,
    input  logic [1:0]            irq_alt_req,
    input  logic                  sel_wr_en,
    input  logic [7:0]            sel_wr_data,
    input  logic [NUM_LEVELS-1:0] sw_clear,
    input  logic                  ack_valid,
    input  logic [LVL_W-1:0]      ack_level,
    output logic [NUM_LEVELS-1:0] pending,
    output logic                  top_valid,
    output logic [LVL_W-1:0]      top_level
);
    sel_vec_t              sel_q;
    logic [NUM_LEVELS-1:0] set_vec;

    shirq_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel_q_o (sel_q)
    );

    shirq_route #(.NUM_LEVELS(NUM_LEVELS)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .req     (irq_req),
        .alt_req (irq_alt_req),
        .set_vec (set_vec)
    );

    shirq_latch_bank #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (sw_clear),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .pending_o (pending)
    );

    shirq_prio #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .top_valid (top_valid),
        .top_level (top_level)
    );

    // R10: a select write alone never lowers a flag
    assert_sel_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_en && !ack_valid && sw_clear == '0) |=> (($past(pending) & ~pending) == '0));
endmodule

// File: tb/shirq_latch_top_test.sv
module shirq_latch_top_test;
    localparam int N = 20;
    localparam int W = 5;

    typedef struct packed {
        logic         we;
        logic [7:0]   wd;
        logic [N-1:0] req;
        logic [1:0]   alt;
        logic [N-1:0] clr;
        logic         av;
        logic [W-1:0] ai;
        logic [N-1:0] ep;
        logic         ev;
        logic [W-1:0] ei;
        logic [3:0]   tag;
    } vec_t;

    // tags: R2 R3 R4 R6 R7 R8 R9 R10 R11
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 20'h00008, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h00008, 1'b1, 5'd3,  4'd2},
        '{1'b0, 8'h00, 20'h00000, 2'b01, 20'h00000, 1'b0, 5'd0,  20'h00008, 1'b1, 5'd3,  4'd3},
        '{1'b0, 8'h00, 20'h08000, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h08008, 1'b1, 5'd3,  4'd3},
        '{1'b0, 8'h00, 20'h00000, 2'b00, 20'h00000, 1'b1, 5'd3,  20'h08000, 1'b1, 5'd15, 4'd6},
        '{1'b1, 8'hFE, 20'h00000, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd10},
        '{1'b0, 8'h00, 20'h00000, 2'b00, 20'h08000, 1'b0, 5'd0,  20'h00000, 1'b0, 5'd0,  4'd7},
        '{1'b0, 8'h00, 20'h08000, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h00000, 1'b0, 5'd0,  4'd3},
        '{1'b0, 8'h00, 20'h00000, 2'b01, 20'h00000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd3},
        '{1'b0, 8'h00, 20'h10000, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h18000, 1'b1, 5'd15, 4'd4},
        '{1'b0, 8'h00, 20'h00000, 2'b10, 20'h10000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd4},
        '{1'b1, 8'h01, 20'h00000, 2'b10, 20'h00000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd11},
        '{1'b0, 8'h00, 20'h00000, 2'b10, 20'h00000, 1'b0, 5'd0,  20'h18000, 1'b1, 5'd15, 4'd4},
        '{1'b0, 8'h00, 20'h10000, 2'b00, 20'h10000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd4},
        '{1'b0, 8'h00, 20'h08000, 2'b00, 20'h08000, 1'b0, 5'd0,  20'h08000, 1'b1, 5'd15, 4'd8},
        '{1'b0, 8'h00, 20'h08000, 2'b00, 20'h00000, 1'b1, 5'd15, 20'h08000, 1'b1, 5'd15, 4'd8},
        '{1'b0, 8'h00, 20'h00000, 2'b00, 20'h00000, 1'b1, 5'd15, 20'h00000, 1'b0, 5'd0,  4'd6},
        '{1'b0, 8'h00, 20'h80081, 2'b00, 20'h00000, 1'b0, 5'd0,  20'h80081, 1'b1, 5'd0,  4'd9},
        '{1'b0, 8'h00, 20'h00000, 2'b00, 20'h00000, 1'b1, 5'd0,  20'h80080, 1'b1, 5'd7,  4'd6},
        '{1'b0, 8'h00, 20'h00000, 2'b00, 20'hFFFFF, 1'b0, 5'd0,  20'h00000, 1'b0, 5'd0,  4'd7}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [1:0]   irq_alt_req = '0;
    logic         sel_wr_en = 1'b0;
    logic [7:0]   sel_wr_data = '0;
    logic [N-1:0] sw_clear = '0;
    logic         ack_valid = 1'b0;
    logic [W-1:0] ack_level = '0;
    logic [N-1:0] pending;
    logic         top_valid;
    logic [W-1:0] top_level;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    shirq_latch_top #(.NUM_LEVELS(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_alt_req(irq_alt_req),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .sw_clear(sw_clear),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .pending(pending), .top_valid(top_valid), .top_level(top_level)
    );

    task automatic check(input string rq, input logic [N-1:0] ep, input logic ev, input logic [W-1:0] ei);
        checks++;
        if (pending !== ep || top_valid !== ev || (ev && top_level !== ei)) begin
            fails++;
            $display("FAIL %s: pending=%h valid=%b level=%0d, expected pending=%h valid=%b level=%0d",
                     rst_n ? rq : rq, pending, top_valid, top_level, ep, ev, ei);
        end
    endtask

    // inputs held for one edge, outputs read at the falling edge after it
    task automatic step(input logic we, input logic [7:0] wd, input logic [N-1:0] rq,
                        input logic [1:0] al, input logic [N-1:0] cl, input logic av, input logic [W-1:0] ai);
        sel_wr_en = we; sel_wr_data = wd; irq_req = rq; irq_alt_req = al;
        sw_clear = cl; ack_valid = av; ack_level = ai;
        @(posedge clk);
        @(negedge clk);
        sel_wr_en = 1'b0; sel_wr_data = '0; irq_req = '0; irq_alt_req = '0;
        sw_clear = '0; ack_valid = 1'b0; ack_level = '0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", '0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", '0, 1'b0, '0);

        for (int v = 0; v < NV; v++) begin
            step(VECS[v].we, VECS[v].wd, VECS[v].req, VECS[v].alt, VECS[v].clr, VECS[v].av, VECS[v].ai);
            check($sformatf("R%0d vector %0d", VECS[v].tag, v), VECS[v].ep, VECS[v].ev, VECS[v].ei);
        end

        // R1: reset in mid-run wipes flags and select bits
        step(1'b1, 8'h03, 20'h00100, 2'b00, '0, 1'b0, '0);
        check("R1 preset flag", 20'h00100, 1'b1, 5'd8);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 async reset", '0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b0, 8'h00, 20'h18000, 2'b11, '0, 1'b0, '0);
        check("R1 select cleared, primaries routed", 20'h18000, 1'b1, 5'd15);
        step(1'b0, 8'h00, '0, 2'b11, 20'h18000, 1'b0, '0);
        check("R1 alternates dropped after reset", '0, 1'b0, '0);

        // R5: upper byte bits do not change routing
        step(1'b1, 8'hFC, '0, 2'b00, '0, 1'b0, '0);
        step(1'b0, 8'h00, '0, 2'b11, '0, 1'b0, '0);
        check("R5 alternates still dropped", '0, 1'b0, '0);
        step(1'b0, 8'h00, 20'h18000, 2'b00, '0, 1'b0, '0);
        check("R5 primaries still routed", 20'h18000, 1'b1, 5'd15);

        // R6: out-of-range acknowledge touches nothing
        step(1'b0, 8'h00, '0, 2'b00, '0, 1'b1, 5'd31);
        check("R6 stray acknowledge", 20'h18000, 1'b1, 5'd15);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule